// File: doc/BRIEF.md
# Activity Monitor Control Register with Privilege-Gated Access

This block keeps the global control word for two groups of activity counters, an architected group and an auxiliary group. It judges every system-register request against the current privilege level, the levels the core implements and a set of trap-control inputs. For each request it reports, in the same cycle as the strobe, whether the access completes, traps to a named level, or is undefined. A completed read also returns its data in that cycle.

The control word is 64 bits wide and has two live bits. The freeze bit (bit 10) stops every counter while the core sits in debug halt. The hide bit (bit 17) makes system-register reads of auxiliary counters return zero below the highest implemented level. Memory-mapped reads of the auxiliary counters always see the true count. Each counter is CNT_W bits wide and advances by one on each event pulse.

Top module: `actmon_ctl`

## Requirements
- R1: After a synchronous reset the control word reads 0 and every counter reads 0.
- R2: Only bit 10 (freeze) and bit 17 (hide) of the control word hold state. All other bits read 0 whatever was written.
- R3: A control-word write (req_kind 0) completes (verdict 00) only when cur_lvl equals the highest implemented level. That level is 3 if has_l3 is set, else 2 if has_l2 is set, else 1. A completed write is visible from the next clock edge. At any other level the verdict is 10 (undefined) and the word keeps its value.
- R4: A control-word read at level 0 is judged in this order, and the first match wins. (a) has_l3, undef_prio and mon_trap all set: undefined. (b) user_en clear: trap, to level 2 when l2_en and host_route are both set, else to level 1. (c) l2_en and hyp_trap both set: trap to level 2. (d) has_l3 and mon_trap both set: undefined if undef_sdd is set, else trap to level 3. (e) Otherwise the read completes.
- R5: A control-word read at level 1 uses the R4 order without step (b). At level 2 it uses only steps (a) and (d). At level 3 it always completes.
- R6: A trap verdict (01) carries trap_class 0x18 and a nonzero trap_lvl. The verdicts complete (00) and undefined (10) carry trap_lvl 0 and trap_class 0.
- R7: Each counter advances by one on each clock edge at which its event input is high, and wraps modulo 2^CNT_W.
- R8: While freeze is set and dbg_halted is high, no counter changes. With freeze clear, counting goes on during debug halt. A write that changes freeze governs counting only from the next edge.
- R9: While hide is set, a system-register read of an auxiliary counter (req_kind 2) below the highest implemented level completes and returns 0. The following reads return the true count: the same read at the highest level, a memory-mapped read (req_kind 3) at any level, and an architected counter read (req_kind 1).
- R10: Counter reads (req_kind 1, 2, 3) always complete. A write with any of these kinds is undefined and leaves every counter unchanged.
- R11: rd_data is 0 whenever there is no request, the request is a write, or the verdict is not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| has_l2 | input | 1 | Level 2 is implemented |
| has_l3 | input | 1 | Level 3 is implemented |
| l2_en | input | 1 | Level 2 is enabled in the current state |
| user_en | input | 1 | Level-0 access enable |
| host_route | input | 1 | Send level-0 enable traps to level 2 |
| hyp_trap | input | 1 | Level-2 trap control for monitor access |
| mon_trap | input | 1 | Level-3 trap control for monitor access |
| undef_prio | input | 1 | Level-3 undefined check takes top priority |
| undef_sdd | input | 1 | Level-3 trap becomes undefined |
| dbg_halted | input | 1 | Core is halted in debug state |
| arch_evt | input | GRP_N | Event pulses, architected counters |
| aux_evt | input | GRP_N | Event pulses, auxiliary counters |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 0 control word, 1 architected counter, 2 auxiliary counter (system view), 3 auxiliary counter (memory-mapped view) |
| req_idx | input | IDX_W | Counter index within its group |
| req_wdata | input | 64 | Write data |
| rd_data | output | 64 | Read data, zero-extended |
| verdict | output | 2 | 00 complete, 01 trap, 10 undefined |
| trap_lvl | output | 2 | Trap target level |
| trap_class | output | 6 | Exception class code of a trap |

## Verification
A control-word write that flips the freeze bit can land in the same cycle as an event pulse while dbg_halted is high. The bench drives the write and the pulse together, in both directions, and reads the counter back afterwards. It expects the setting in force before the write to decide that cycle's count: the pulse counts when freeze is being set, and is frozen when freeze is being cleared. The read-zero rule is judged the same way. Flipping has_l3 moves the highest level between 3 and 2, and the bench checks that an auxiliary read at level 2 changes from hidden to visible.

// File: rtl/actmon_pkg.sv
package actmon_pkg;
  localparam int WORD_W    = 64;
  localparam int FREEZE_POS = 10;
  localparam int HIDE_POS   = 17;
  localparam logic [WORD_W-1:0] LIVE_MASK =
    (WORD_W'(1) << FREEZE_POS) | (WORD_W'(1) << HIDE_POS);
  localparam logic [5:0] TRAP_CLASS = 6'h18;

  typedef enum logic [1:0] {
    VD_DONE  = 2'd0,
    VD_TRAP  = 2'd1,
    VD_UNDEF = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    K_CTRL    = 2'd0,
    K_ARCH    = 2'd1,
    K_AUX_SYS = 2'd2,
    K_AUX_MEM = 2'd3
  } kind_e;
endpackage

// File: rtl/actmon_access_check.sv
module actmon_access_check
  import actmon_pkg::*;
(
  input  logic       req_valid,
  input  logic       is_write,
  input  logic [1:0] kind,
  input  logic [1:0] cur_lvl,
  input  logic [1:0] top_lvl,
  input  logic       has_l3,
  input  logic       l2_en,
  input  logic       user_en,
  input  logic       host_route,
  input  logic       hyp_trap,
  input  logic       mon_trap,
  input  logic       undef_prio,
  input  logic       undef_sdd,
  output logic [1:0] vd,
  output logic [1:0] tgt,
  output logic [5:0] ec
);
  logic early_undef;
  logic l2_hit;
  logic l3_hit;
  verdict_e vd_c;
  logic [1:0] tgt_c;

  assign early_undef = has_l3 & undef_prio & mon_trap;
  assign l2_hit      = l2_en & hyp_trap;
  assign l3_hit      = has_l3 & mon_trap;

  always_comb begin
    vd_c  = VD_DONE;
    tgt_c = 2'd0;
    if (req_valid) begin
      if (kind != K_CTRL) begin
        if (is_write) vd_c = VD_UNDEF;
      end else if (is_write) begin
        if (cur_lvl != top_lvl) vd_c = VD_UNDEF;
      end else begin
        case (cur_lvl)
          2'd0: begin
            if (early_undef) vd_c = VD_UNDEF;
            else if (!user_en) begin
              vd_c  = VD_TRAP;
              tgt_c = (l2_en && host_route) ? 2'd2 : 2'd1;
            end else if (l2_hit) begin
              vd_c  = VD_TRAP;
              tgt_c = 2'd2;
            end else if (l3_hit) begin
              if (undef_sdd) vd_c = VD_UNDEF;
              else begin
                vd_c  = VD_TRAP;
                tgt_c = 2'd3;
              end
            end
          end
          2'd1: begin
            if (early_undef) vd_c = VD_UNDEF;
            else if (l2_hit) begin
              vd_c  = VD_TRAP;
              tgt_c = 2'd2;
            end else if (l3_hit) begin
              if (undef_sdd) vd_c = VD_UNDEF;
              else begin
                vd_c  = VD_TRAP;
                tgt_c = 2'd3;
              end
            end
          end
          2'd2: begin
            if (early_undef) vd_c = VD_UNDEF;
            else if (l3_hit) begin
              if (undef_sdd) vd_c = VD_UNDEF;
              else begin
                vd_c  = VD_TRAP;
                tgt_c = 2'd3;
              end
            end
          end
          default: vd_c = VD_DONE;
        endcase
      end
    end
  end

  assign vd  = vd_c;
  assign tgt = tgt_c;
  assign ec  = (vd_c == VD_TRAP) ? TRAP_CLASS : 6'd0;
endmodule

// File: rtl/actmon_ctl_reg.sv
module actmon_ctl_reg
  import actmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word,
  output logic              freeze,
  output logic              hide
);
  logic [WORD_W-1:0] word_q;

  // Dead bits are masked on entry, so they stay constant zero.
  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (wr_en) word_q <= wdata & LIVE_MASK;
  end

  assign word   = word_q;
  assign freeze = word_q[FREEZE_POS];
  assign hide   = word_q[HIDE_POS];
endmodule

// File: rtl/actmon_counter_bank.sv
module actmon_counter_bank #(
  parameter int GRP_N = 4,
  parameter int CNT_W = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hold,
  input  logic [GRP_N-1:0]            evt,
  output logic [GRP_N-1:0][CNT_W-1:0] cnt
);
  for (genvar g = 0; g < GRP_N; g++) begin : g_cnt
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk) begin
      if (rst)                 c_q <= '0;
      else if (evt[g] && !hold) c_q <= c_q + CNT_W'(1);
    end
    assign cnt[g] = c_q;
  end
endmodule

// File: rtl/actmon_ctl.sv
module actmon_ctl
  import actmon_pkg::*;
#(
  parameter int GRP_N = 4,
  parameter int CNT_W = 64,
  parameter int IDX_W = (GRP_N > 1) ? $clog2(GRP_N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cur_lvl,
  input  logic             has_l2,
  input  logic             has_l3,
  input  logic             l2_en,
  input  logic             user_en,
  input  logic             host_route,
  input  logic             hyp_trap,
  input  logic             mon_trap,
  input  logic             undef_prio,
  input  logic             undef_sdd,
  input  logic             dbg_halted,
  input  logic [GRP_N-1:0] arch_evt,
  input  logic [GRP_N-1:0] aux_evt,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_kind,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [63:0]      req_wdata,
  output logic [63:0]      rd_data,
  output logic [1:0]       verdict,
  output logic [1:0]       trap_lvl,
  output logic [5:0]       trap_class
);
  logic [1:0]                  top_lvl;
  logic [1:0]                  vd;
  logic                        ctl_wr;
  logic [WORD_W-1:0]           ctl_word;
  logic                        freeze;
  logic                        hide;
  logic                        hold;
  logic [GRP_N-1:0][CNT_W-1:0] arch_cnt;
  logic [GRP_N-1:0][CNT_W-1:0] aux_cnt;
  logic [63:0]                 rd_c;

  assign top_lvl = has_l3 ? 2'd3 : (has_l2 ? 2'd2 : 2'd1);

  actmon_access_check u_chk_acc (
    .req_valid (req_valid),
    .is_write  (req_write),
    .kind      (req_kind),
    .cur_lvl   (cur_lvl),
    .top_lvl   (top_lvl),
    .has_l3    (has_l3),
    .l2_en     (l2_en),
    .user_en   (user_en),
    .host_route(host_route),
    .hyp_trap  (hyp_trap),
    .mon_trap  (mon_trap),
    .undef_prio(undef_prio),
    .undef_sdd (undef_sdd),
    .vd        (vd),
    .tgt       (trap_lvl),
    .ec        (trap_class)
  );

  assign ctl_wr = req_valid && req_write && (req_kind == K_CTRL) && (vd == VD_DONE);

  actmon_ctl_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (ctl_wr),
    .wdata (req_wdata),
    .word  (ctl_word),
    .freeze(freeze),
    .hide  (hide)
  );

  assign hold = freeze & dbg_halted;

  actmon_counter_bank #(.GRP_N(GRP_N), .CNT_W(CNT_W)) u_arch (
    .clk (clk),
    .rst (rst),
    .hold(hold),
    .evt (arch_evt),
    .cnt (arch_cnt)
  );

  actmon_counter_bank #(.GRP_N(GRP_N), .CNT_W(CNT_W)) u_aux (
    .clk (clk),
    .rst (rst),
    .hold(hold),
    .evt (aux_evt),
    .cnt (aux_cnt)
  );

  // Read data is formed in the request cycle, together with the verdict.
  always_comb begin
    rd_c = '0;
    if (req_valid && !req_write && vd == VD_DONE) begin
      case (req_kind)
        K_CTRL:    rd_c = ctl_word;
        K_ARCH:    rd_c[CNT_W-1:0] = arch_cnt[req_idx];
        K_AUX_SYS: if (!hide || cur_lvl == top_lvl) rd_c[CNT_W-1:0] = aux_cnt[req_idx];
        default:   rd_c[CNT_W-1:0] = aux_cnt[req_idx];
      endcase
    end
  end

  assign rd_data = rd_c;
  assign verdict = vd;
endmodule

// File: rtl/actmon_ctl_chk.sv
module actmon_ctl_chk
  import actmon_pkg::*;
#(
  parameter int GRP_N = 4,
  parameter int CNT_W = 64
) (
  input logic                        clk,
  input logic                        rst,
  input logic [1:0]                  cur_lvl,
  input logic                        has_l2,
  input logic                        has_l3,
  input logic                        user_en,
  input logic                        undef_prio,
  input logic                        mon_trap,
  input logic                        dbg_halted,
  input logic                        req_valid,
  input logic                        req_write,
  input logic [1:0]                  req_kind,
  input logic [63:0]                 req_wdata,
  input logic [63:0]                 rd_data,
  input logic [1:0]                  verdict,
  input logic [1:0]                  trap_lvl,
  input logic [5:0]                  trap_class,
  input logic [WORD_W-1:0]           ctl_word,
  input logic [GRP_N-1:0][CNT_W-1:0] arch_cnt,
  input logic [GRP_N-1:0][CNT_W-1:0] aux_cnt
);
  logic [1:0] hi_lvl;
  logic       ctl_wr_req;
  assign hi_lvl     = has_l3 ? 2'd3 : (has_l2 ? 2'd2 : 2'd1);
  assign ctl_wr_req = req_valid && req_write && req_kind == 2'd0;

  assert_wr_commit_R3: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_req && cur_lvl == hi_lvl |=> ctl_word == ($past(req_wdata) & LIVE_MASK));

  assert_wr_reject_R3: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_req && cur_lvl != hi_lvl |-> verdict == 2'd2 ##1 $stable(ctl_word));

  assert_dead_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_word & ~LIVE_MASK) == '0);

  assert_top_level_read_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && req_kind == 2'd0 && cur_lvl == 2'd3 |-> verdict == 2'd0);

  assert_user_gate_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && req_kind == 2'd0 && cur_lvl == 2'd0 && !user_en &&
    !(has_l3 && undef_prio && mon_trap) |-> verdict == 2'd1 && trap_lvl != 2'd3);

  assert_trap_class_R6: assert property (@(posedge clk) disable iff (rst)
    verdict == 2'd1 |-> trap_class == 6'h18 && trap_lvl != 2'd0);

  assert_no_trap_fields_R6: assert property (@(posedge clk) disable iff (rst)
    verdict != 2'd1 |-> trap_class == 6'd0 && trap_lvl == 2'd0);

  assert_debug_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_word[FREEZE_POS] && dbg_halted |=> $stable(arch_cnt) && $stable(aux_cnt));

  assert_counter_write_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write && req_kind != 2'd0 |-> verdict == 2'd2);

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid || req_write || verdict != 2'd0 |-> rd_data == 64'd0);
endmodule

bind actmon_ctl actmon_ctl_chk #(.GRP_N(GRP_N), .CNT_W(CNT_W)) u_props (
  .clk       (clk),
  .rst       (rst),
  .cur_lvl   (cur_lvl),
  .has_l2    (has_l2),
  .has_l3    (has_l3),
  .user_en   (user_en),
  .undef_prio(undef_prio),
  .mon_trap  (mon_trap),
  .dbg_halted(dbg_halted),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_kind  (req_kind),
  .req_wdata (req_wdata),
  .rd_data   (rd_data),
  .verdict   (verdict),
  .trap_lvl  (trap_lvl),
  .trap_class(trap_class),
  .ctl_word  (ctl_word),
  .arch_cnt  (arch_cnt),
  .aux_cnt   (aux_cnt)
);

// File: tb/actmon_ctl_tb.sv
module actmon_ctl_tb;
  localparam int GRP_N = 4;
  localparam int CNT_W = 4;
  localparam logic [63:0] FRZ = 64'h400;
  localparam logic [63:0] HID = 64'h2_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cur_lvl = 2'd3;
  logic has_l2 = 1'b1, has_l3 = 1'b1, l2_en = 1'b0, user_en = 1'b1;
  logic host_route = 1'b0, hyp_trap = 1'b0, mon_trap = 1'b0;
  logic undef_prio = 1'b0, undef_sdd = 1'b0, dbg_halted = 1'b0;
  logic [GRP_N-1:0] arch_evt = '0, aux_evt = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [1:0] req_idx = 2'd0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rd_data;
  logic [1:0] verdict, trap_lvl;
  logic [5:0] trap_class;

  int n_vec = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  actmon_ctl #(.GRP_N(GRP_N), .CNT_W(CNT_W)) u_dut (.*);

  // {lvl, has_l2 has_l3 l2_en user_en host_route hyp_trap mon_trap undef_prio undef_sdd, verdict, target}
  localparam logic [14:0] VEC [18] = '{
    {2'd0, 9'b111100110, 2'd2, 2'd0},
    {2'd0, 9'b111010000, 2'd1, 2'd2},
    {2'd0, 9'b110010000, 2'd1, 2'd1},
    {2'd0, 9'b111000000, 2'd1, 2'd1},
    {2'd0, 9'b111101000, 2'd1, 2'd2},
    {2'd0, 9'b110100101, 2'd2, 2'd0},
    {2'd0, 9'b110100100, 2'd1, 2'd3},
    {2'd0, 9'b111100000, 2'd0, 2'd0},
    {2'd0, 9'b101100111, 2'd0, 2'd0},
    {2'd1, 9'b111010000, 2'd0, 2'd0},
    {2'd1, 9'b111001000, 2'd1, 2'd2},
    {2'd1, 9'b111001110, 2'd2, 2'd0},
    {2'd1, 9'b110001100, 2'd1, 2'd3},
    {2'd2, 9'b111001000, 2'd0, 2'd0},
    {2'd2, 9'b110000101, 2'd2, 2'd0},
    {2'd2, 9'b110000110, 2'd2, 2'd0},
    {2'd2, 9'b110000100, 2'd1, 2'd3},
    {2'd3, 9'b111111111, 2'd0, 2'd0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [63:0] s_rd;
  logic [1:0]  s_vd, s_tl;
  logic [5:0]  s_ec;

  // Drive one request at a negedge, sample before the posedge, release after it.
  task automatic access(input logic [1:0] lvl, input logic [1:0] kind, input logic [1:0] idx,
                        input logic wr, input logic [63:0] wd);
    @(negedge clk);
    cur_lvl = lvl; req_kind = kind; req_idx = idx; req_write = wr; req_wdata = wd;
    req_valid = 1'b1;
    #1;
    s_rd = rd_data; s_vd = verdict; s_tl = trap_lvl; s_ec = trap_class;
    @(posedge clk);
    #1 req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic pulse(input logic [GRP_N-1:0] a, input logic [GRP_N-1:0] x, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      arch_evt = a; aux_evt = x;
      @(posedge clk);
      #1 arch_evt = '0; aux_evt = '0;
    end
  endtask

  task automatic std_env();
    has_l2 = 1; has_l3 = 1; l2_en = 0; user_en = 1; host_route = 0;
    hyp_trap = 0; mon_trap = 0; undef_prio = 0; undef_sdd = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [14:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    access(2'd3, 2'd0, 2'd0, 1'b0, '0); chk("R1 ctrl", s_rd, 64'd0);
    access(2'd3, 2'd1, 2'd0, 1'b0, '0); chk("R1 arch0", s_rd, 64'd0);
    access(2'd3, 2'd3, 2'd3, 1'b0, '0); chk("R1 aux3", s_rd, 64'd0);
    #1 chk("R11 idle", rd_data, 64'd0);

    // R3 writes below highest level rejected
    access(2'd1, 2'd0, 2'd0, 1'b1, '1); chk("R3 low write verdict", 64'(s_vd), 64'd2);
    access(2'd2, 2'd0, 2'd0, 1'b1, '1); chk("R3 L2 write verdict", 64'(s_vd), 64'd2);
    access(2'd3, 2'd0, 2'd0, 1'b0, '0); chk("R3 unchanged", s_rd, 64'd0);
    // R3 highest level 2 when level 3 absent
    has_l3 = 0;
    access(2'd2, 2'd0, 2'd0, 1'b1, FRZ); chk("R3 L2 top write", 64'(s_vd), 64'd0);
    access(2'd2, 2'd0, 2'd0, 1'b0, '0); chk("R3 L2 readback", s_rd, FRZ);
    has_l3 = 1;
    // R2 dead bits
    access(2'd3, 2'd0, 2'd0, 1'b1, '1);
    access(2'd3, 2'd0, 2'd0, 1'b0, '0); chk("R2 live bits only", s_rd, FRZ | HID);

    // R4 / R5 / R6 / R11 permission table
    for (int i = 0; i < 18; i++) begin
      v = VEC[i];
      {has_l2, has_l3, l2_en, user_en, host_route, hyp_trap, mon_trap, undef_prio, undef_sdd} = v[12:4];
      access(v[14:13], 2'd0, 2'd0, 1'b0, '0);
      if (v[14:13] == 2'd0) begin
        chk($sformatf("R4 verdict vec%0d", i), 64'(s_vd), 64'(v[3:2]));
        chk($sformatf("R4 target vec%0d", i), 64'(s_tl), 64'(v[1:0]));
      end else begin
        chk($sformatf("R5 verdict vec%0d", i), 64'(s_vd), 64'(v[3:2]));
        chk($sformatf("R5 target vec%0d", i), 64'(s_tl), 64'(v[1:0]));
      end
      chk($sformatf("R6 class vec%0d", i), 64'(s_ec), (v[3:2] == 2'd1) ? 64'h18 : 64'd0);
      chk($sformatf("R11 data vec%0d", i), s_rd, (v[3:2] == 2'd0) ? (FRZ | HID) : 64'd0);
    end
    std_env();
    access(2'd3, 2'd0, 2'd0, 1'b1, '0);

    // R7 counting and wrap
    pulse(4'b0001, 4'b0000, 3);
    access(2'd3, 2'd1, 2'd0, 1'b0, '0); chk("R7 arch0 count", s_rd, 64'd3);
    access(2'd3, 2'd1, 2'd1, 1'b0, '0); chk("R7 arch1 untouched", s_rd, 64'd0);
    pulse(4'b0000, 4'b0010, 17);
    access(2'd0, 2'd3, 2'd1, 1'b0, '0); chk("R7 aux1 wrap", s_rd, 64'd1);

    // R10 counter writes
    access(2'd3, 2'd1, 2'd0, 1'b1, 64'hF); chk("R10 write verdict", 64'(s_vd), 64'd2);
    access(2'd3, 2'd1, 2'd0, 1'b0, '0); chk("R10 count kept", s_rd, 64'd3);
    access(2'd0, 2'd2, 2'd1, 1'b0, '0); chk("R10 read completes", 64'(s_vd), 64'd0);

    // R9 hide
    access(2'd3, 2'd0, 2'd0, 1'b1, HID);
    pulse(4'b0000, 4'b0100, 5);
    access(2'd1, 2'd2, 2'd2, 1'b0, '0); chk("R9 hidden low", s_rd, 64'd0);
    chk("R9 hidden verdict", 64'(s_vd), 64'd0);
    access(2'd3, 2'd2, 2'd2, 1'b0, '0); chk("R9 visible top", s_rd, 64'd5);
    access(2'd0, 2'd3, 2'd2, 1'b0, '0); chk("R9 mmio view", s_rd, 64'd5);
    access(2'd1, 2'd1, 2'd0, 1'b0, '0); chk("R9 arch unaffected", s_rd, 64'd3);
    access(2'd2, 2'd2, 2'd2, 1'b0, '0); chk("R9 hidden at L2", s_rd, 64'd0);
    has_l3 = 0;
    access(2'd2, 2'd2, 2'd2, 1'b0, '0); chk("R9 L2 as top", s_rd, 64'd5);
    has_l3 = 1;

    // R8 freeze in debug halt
    access(2'd3, 2'd0, 2'd0, 1'b1, FRZ);
    dbg_halted = 1;
    pulse(4'b0001, 4'b0100, 2);
    access(2'd3, 2'd1, 2'd0, 1'b0, '0); chk("R8 frozen arch", s_rd, 64'd3);
    access(2'd3, 2'd3, 2'd2, 1'b0, '0); chk("R8 frozen aux", s_rd, 64'd5);
    dbg_halted = 0;
    pulse(4'b0001, 4'b0000, 1);
    access(2'd3, 2'd1, 2'd0, 1'b0, '0); chk("R8 runs when not halted", s_rd, 64'd4);
    access(2'd3, 2'd0, 2'd0, 1'b1, '0);
    dbg_halted = 1;
    pulse(4'b0001, 4'b0000, 2);
    access(2'd3, 2'd1, 2'd0, 1'b0, '0); chk("R8 runs with freeze clear", s_rd, 64'd6);

    // R8 same cycle: setting freeze together with an event still counts it
    @(negedge clk);
    cur_lvl = 2'd3; req_kind = 2'd0; req_write = 1; req_wdata = FRZ; req_valid = 1;
    arch_evt = 4'b0001;
    @(posedge clk);
    #1 req_valid = 0; req_write = 0; arch_evt = '0;
    pulse(4'b0001, 4'b0000, 1);
    access(2'd3, 2'd1, 2'd0, 1'b0, '0); chk("R8 same-cycle set", s_rd, 64'd7);
    // clearing freeze together with an event: that event is still frozen
    @(negedge clk);
    req_kind = 2'd0; req_write = 1; req_wdata = '0; req_valid = 1;
    arch_evt = 4'b0001;
    @(posedge clk);
    #1 req_valid = 0; req_write = 0; arch_evt = '0;
    access(2'd3, 2'd1, 2'd0, 1'b0, '0); chk("R8 same-cycle clear", s_rd, 64'd7);
    pulse(4'b0001, 4'b0000, 1);
    access(2'd3, 2'd1, 2'd0, 1'b0, '0); chk("R8 after clear", s_rd, 64'd8);
    dbg_halted = 0;

    // R1 reset again clears everything
    access(2'd3, 2'd0, 2'd0, 1'b1, HID);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    access(2'd3, 2'd0, 2'd0, 1'b0, '0); chk("R1 ctrl after reset", s_rd, 64'd0);
    access(2'd3, 2'd1, 2'd0, 1'b0, '0); chk("R1 arch after reset", s_rd, 64'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule